// File: doc/BRIEF.md
# Receive Packet Metadata Encapsulator

This block sits in a receive word stream, just before the stage that writes packets into memory buffers. For each packet it can insert up to three kinds of side information into the data. A classification word goes in front of the payload. A 64-bit capture time goes in front as two words. A 32-bit checksum word is appended after the payload. The downstream writer then stores the metadata in the buffer as ordinary packet bytes.

The stream is 32 bits wide, little-endian within a word. It carries start and end markers and a 4-bit byte-enable, which is contiguous from lane 0 and may be partial only on the end word. The three metadata values and their three enables are sampled once per packet, in the first cycle that a start word is offered while the block is idle. They are then held for the whole packet. Output stalls propagate upstream through a combinational ready, and the block holds no payload storage of its own. A word offered while idle without a start marker is accepted and discarded.

At the end of each packet the block reports the total byte count of the packet, inserted bytes included. It also reports a flag word for the first descriptor of the packet.

Top module: `rx_meta_encap`

## Requirements
- R1: After reset, out_valid, in_ready and desc_valid are all low until a start word is offered.
- R2: With the classification enable set, the first output word of the packet is the classification word, with full byte-enable, and it carries the output start marker.
- R3: With the time enable set, two full words follow any classification word and precede the payload: the lower 32 time bits first, then the upper 32 bits.
- R4: Payload bytes leave unchanged and in order. The start marker moves to the first inserted word when a prefix is present, and the end marker stays on the last payload word when no checksum is appended.
- R5: With the checksum enable set and a full last payload word, one extra word holding the checksum, with byte-enable 4'b1111, ends the packet.
- R6: With the checksum enable set and k valid bytes (1 to 3) in the last payload word, that word leaves with byte-enable 4'b1111 and carries the low 4-k checksum bytes in its upper lanes. A final word then holds the remaining k checksum bytes in its low lanes, with byte-enable (1<<k)-1.
- R7: One cycle after the output end word is accepted, desc_valid pulses for one cycle. desc_len then equals the number of enabled output bytes of that packet, modulo 2^LEN_W.
- R8: Alongside desc_valid, desc_flags has bit 19 equal to the sampled classification enable, bit 15 equal to the sampled time enable and bit 12 equal to the sampled checksum enable, with every other bit zero.
- R9: Changes to the enables or metadata inputs after the start word has been sampled have no effect on that packet's output words or descriptor.
- R10: While out_valid is high and out_ready low, the output word, byte-enable and markers hold. Every expected word leaves exactly once.
- R11: A payload word is accepted (in_valid and in_ready) only in a cycle in which the output also completes a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 32 | Input payload word |
| in_be | input | 4 | Input byte-enable, contiguous from lane 0 |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| en_vlan | input | 1 | Insert classification word |
| en_ts | input | 1 | Insert 64-bit capture time |
| en_csum | input | 1 | Append checksum word |
| vlan_word | input | 32 | Classification word value |
| ts_value | input | 64 | Capture time value |
| csum_word | input | 32 | Checksum word value |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Output word |
| out_be | output | 4 | Output byte-enable |
| out_sop | output | 1 | Output first word |
| out_eop | output | 1 | Output last word |
| desc_valid | output | 1 | Descriptor info valid, one cycle |
| desc_len | output | LEN_W | Packet byte count |
| desc_flags | output | 32 | Encapsulation flags for the first descriptor |

## Verification
The bench builds the block with LEN_W set to 8 instead of the default 12. A packet of about seventy payload words with all three inserts then overflows the byte counter, so the modulo wrap of the reported length can be reached within a short run. Every enable combination and every last-word fill from one to four bytes is driven. Downstream ready follows an always-on pattern, an alternating pattern and a pseudo-random pattern.

// File: rtl/rme_pkg.sv
package rme_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_VLAN = 3'd1,
    ST_TSLO = 3'd2,
    ST_TSHI = 3'd3,
    ST_PAY  = 3'd4,
    ST_TAIL = 3'd5
  } rme_state_e;

  localparam int FLAG_VLAN_POS = 19;
  localparam int FLAG_TS_POS   = 15;
  localparam int FLAG_CSUM_POS = 12;

  function automatic logic [2:0] be_count(input logic [3:0] be);
    be_count = 3'(be[0]) + 3'(be[1]) + 3'(be[2]) + 3'(be[3]);
  endfunction

  function automatic logic [3:0] be_from_count(input logic [2:0] n);
    case (n)
      3'd1:    be_from_count = 4'b0001;
      3'd2:    be_from_count = 4'b0011;
      3'd3:    be_from_count = 4'b0111;
      default: be_from_count = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    be_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/rme_fsm.sv
module rme_fsm
  import rme_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [3:0] in_be,
  input  logic       en_vlan,
  input  logic       en_ts,
  input  logic       en_csum,
  input  logic       out_fire,
  output rme_state_e state,
  output logic       capture,
  output logic       vlan_on,
  output logic       ts_on,
  output logic       csum_on,
  output logic       sop_pend,
  output logic [2:0] last_nb
);

  rme_state_e state_q, state_d;
  logic       vlan_q, ts_q, csum_q, sop_q, sop_d;
  logic [2:0] nb_q;
  logic       last_ld;

  // next-state logic
  always_comb begin
    capture = (state_q == ST_IDLE) && in_valid && in_sop;
    last_ld = (state_q == ST_PAY) && out_fire && in_eop;
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (capture) state_d = en_vlan ? ST_VLAN : (en_ts ? ST_TSLO : ST_PAY);
      ST_VLAN: if (out_fire) state_d = ts_q ? ST_TSLO : ST_PAY;
      ST_TSLO: if (out_fire) state_d = ST_TSHI;
      ST_TSHI: if (out_fire) state_d = ST_PAY;
      ST_PAY:  if (last_ld) state_d = csum_q ? ST_TAIL : ST_IDLE;
      ST_TAIL: if (out_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    sop_d = capture ? 1'b1 : (out_fire ? 1'b0 : sop_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sop_q   <= 1'b0;
      vlan_q  <= 1'b0;
      ts_q    <= 1'b0;
      csum_q  <= 1'b0;
      nb_q    <= 3'd4;
    end else begin
      state_q <= state_d;
      sop_q   <= sop_d;
      if (capture) begin
        vlan_q <= en_vlan;
        ts_q   <= en_ts;
        csum_q <= en_csum;
      end
      if (last_ld) nb_q <= be_count(in_be);
    end
  end

  assign state    = state_q;
  assign vlan_on  = vlan_q;
  assign ts_on    = ts_q;
  assign csum_on  = csum_q;
  assign sop_pend = sop_q;
  assign last_nb  = nb_q;

  // R3: the upper time word is only ever entered from the lower one
  p_ts_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TSHI) && ($past(state_q) != ST_TSHI) |-> $past(state_q) == ST_TSLO);

  // R2: the start marker is carried by exactly one accepted word
  p_single_sop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && sop_q |=> !sop_q);

endmodule

// File: rtl/rme_datapath.sv
module rme_datapath
  import rme_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  rme_state_e  state,
  input  logic        capture,
  input  logic        csum_on,
  input  logic        sop_pend,
  input  logic [2:0]  last_nb,
  input  logic [31:0] vlan_word,
  input  logic [63:0] ts_value,
  input  logic [31:0] csum_word,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic [3:0]  in_be,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic        out_ready,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic [3:0]  out_be,
  output logic        out_sop,
  output logic        out_eop,
  output logic        out_fire
);

  logic [31:0] vlan_q, csum_q;
  logic [63:0] ts_q;
  logic [2:0]  in_nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlan_q <= '0;
      ts_q   <= '0;
      csum_q <= '0;
    end else if (capture) begin
      vlan_q <= vlan_word;
      ts_q   <= ts_value;
      csum_q <= csum_word;
    end
  end

  always_comb begin
    in_nb     = be_count(in_be);
    out_valid = 1'b0;
    out_data  = '0;
    out_be    = 4'b0000;
    out_eop   = 1'b0;
    in_ready  = 1'b0;
    case (state)
      ST_IDLE: in_ready = in_valid && !in_sop;
      ST_VLAN: begin
        out_valid = 1'b1;
        out_data  = vlan_q;
        out_be    = 4'b1111;
      end
      ST_TSLO: begin
        out_valid = 1'b1;
        out_data  = ts_q[31:0];
        out_be    = 4'b1111;
      end
      ST_TSHI: begin
        out_valid = 1'b1;
        out_data  = ts_q[63:32];
        out_be    = 4'b1111;
      end
      ST_PAY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        if (in_eop && csum_on) begin
          out_be   = 4'b1111;
          out_data = (in_nb == 3'd4) ? in_data
                   : ((in_data & be_mask(in_be)) | (csum_q << {in_nb, 3'b000}));
        end else begin
          out_data = in_data;
          out_be   = in_be;
          out_eop  = in_eop;
        end
      end
      ST_TAIL: begin
        out_valid = 1'b1;
        out_eop   = 1'b1;
        out_be    = be_from_count(last_nb);
        out_data  = (last_nb == 3'd4) ? csum_q : (csum_q >> {3'd4 - last_nb, 3'b000});
      end
      default: ;
    endcase
    out_sop  = sop_pend;
    out_fire = out_valid && out_ready;
  end

  // R10: a stalled word holds until it is taken
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be)
                                && $stable(out_sop) && $stable(out_eop));

  // R11: a payload word is only taken together with an output transfer
  p_xfer_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (state != ST_IDLE) |-> out_valid && out_ready);

endmodule

// File: rtl/rme_len.sv
module rme_len
  import rme_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_fire,
  input  logic [3:0]       out_be,
  input  logic             out_eop,
  input  logic             vlan_on,
  input  logic             ts_on,
  input  logic             csum_on,
  output logic             desc_valid,
  output logic [LEN_W-1:0] desc_len,
  output logic [31:0]      desc_flags
);

  logic [LEN_W-1:0] acc_q, acc_d, sum;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      flags_q, flags_d;
  logic             dv_q, end_hit;

  always_comb begin
    sum     = acc_q + LEN_W'(be_count(out_be));
    end_hit = out_fire && out_eop;
    acc_d   = acc_q;
    if (out_fire) acc_d = end_hit ? '0 : sum;
    flags_d = '0;
    flags_d[FLAG_VLAN_POS] = vlan_on;
    flags_d[FLAG_TS_POS]   = ts_on;
    flags_d[FLAG_CSUM_POS] = csum_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      len_q   <= '0;
      flags_q <= '0;
      dv_q    <= 1'b0;
    end else begin
      acc_q <= acc_d;
      dv_q  <= end_hit;
      if (end_hit) begin
        len_q   <= sum;
        flags_q <= flags_d;
      end
    end
  end

  assign desc_valid = dv_q;
  assign desc_len   = len_q;
  assign desc_flags = flags_q;

  // R7: the descriptor pulse follows an accepted end word by one cycle
  p_desc_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $past(out_fire && out_eop));

  // R7: the pulse lasts a single cycle
  p_desc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> !desc_valid);

endmodule

// File: rtl/rx_meta_encap.sv
module rx_meta_encap
  import rme_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic [3:0]       in_be,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             en_vlan,
  input  logic             en_ts,
  input  logic             en_csum,
  input  logic [31:0]      vlan_word,
  input  logic [63:0]      ts_value,
  input  logic [31:0]      csum_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic [3:0]       out_be,
  output logic             out_sop,
  output logic             out_eop,
  output logic             desc_valid,
  output logic [LEN_W-1:0] desc_len,
  output logic [31:0]      desc_flags
);

  rme_state_e state;
  logic       capture, vlan_on, ts_on, csum_on, sop_pend, out_fire;
  logic [2:0] last_nb;

  rme_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_be(in_be), .en_vlan(en_vlan), .en_ts(en_ts),
    .en_csum(en_csum), .out_fire(out_fire), .state(state), .capture(capture),
    .vlan_on(vlan_on), .ts_on(ts_on), .csum_on(csum_on), .sop_pend(sop_pend),
    .last_nb(last_nb)
  );

  rme_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .capture(capture),
    .csum_on(csum_on), .sop_pend(sop_pend), .last_nb(last_nb),
    .vlan_word(vlan_word), .ts_value(ts_value), .csum_word(csum_word),
    .in_valid(in_valid), .in_data(in_data), .in_be(in_be), .in_sop(in_sop),
    .in_eop(in_eop), .out_ready(out_ready), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_be(out_be),
    .out_sop(out_sop), .out_eop(out_eop), .out_fire(out_fire)
  );

  rme_len #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .out_fire(out_fire), .out_be(out_be),
    .out_eop(out_eop), .vlan_on(vlan_on), .ts_on(ts_on), .csum_on(csum_on),
    .desc_valid(desc_valid), .desc_len(desc_len), .desc_flags(desc_flags)
  );

endmodule

// File: tb/rx_meta_encap_tb.sv
module rx_meta_encap_tb;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_sop, in_eop, en_vlan, en_ts, en_csum;
  logic [31:0] in_data, vlan_word, csum_word, out_data, desc_flags;
  logic [3:0]  in_be, out_be;
  logic [63:0] ts_value;
  logic out_valid, out_ready, out_sop, out_eop, desc_valid;
  logic [LEN_W-1:0] desc_len;

  rx_meta_encap #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_be(in_be), .in_sop(in_sop), .in_eop(in_eop),
    .en_vlan(en_vlan), .en_ts(en_ts), .en_csum(en_csum), .vlan_word(vlan_word),
    .ts_value(ts_value), .csum_word(csum_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_be(out_be),
    .out_sop(out_sop), .out_eop(out_eop), .desc_valid(desc_valid),
    .desc_len(desc_len), .desc_flags(desc_flags)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int rdy_mode = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  logic [31:0] ew_data[$];
  logic [3:0]  ew_be[$];
  bit          ew_sop[$], ew_eop[$];
  string       ew_tag[$];
  int          ed_len[$];
  logic [31:0] ed_flags[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ~out_ready;
      default: out_ready = lfsr[3] | lfsr[7];
    endcase
  end

  // monitor: reference comparison every clock, away from the edge
  bit          prev_stall = 1'b0;
  logic [31:0] p_data;
  logic [3:0]  p_be;
  logic        p_sop, p_eop;
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (prev_stall)
        chk(out_valid && out_data == p_data && out_be == p_be && out_sop == p_sop
            && out_eop == p_eop, "R10", "stalled word changed",
            {out_be, out_data}, {p_be, p_data});
      prev_stall = out_valid && !out_ready;
      p_data = out_data; p_be = out_be; p_sop = out_sop; p_eop = out_eop;
      if (in_valid && in_ready && !(in_sop === 1'b1 && !out_valid))
        chk(out_valid && out_ready, "R11", "input taken without output transfer",
            {out_valid, out_ready}, 2'b11);
      if (out_valid && out_ready) begin
        if (ew_data.size() == 0) begin
          chk(1'b0, "R10", "unexpected extra word", out_data, 0);
        end else begin
          logic [31:0] m;
          logic [31:0] ed;
          logic [3:0]  eb;
          bit          es, ee;
          string       t;
          ed = ew_data.pop_front(); eb = ew_be.pop_front();
          es = ew_sop.pop_front(); ee = ew_eop.pop_front(); t = ew_tag.pop_front();
          m = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
          chk((out_data & m) == (ed & m) && out_be == eb && out_sop == es && out_eop == ee,
              t, "output word", {out_sop, out_eop, out_be, out_data},
              {es, ee, eb, ed & m});
        end
      end
      if (desc_valid) begin
        if (ed_len.size() == 0) begin
          chk(1'b0, "R7", "unexpected descriptor", desc_len, 0);
        end else begin
          int          el;
          logic [31:0] ef;
          el = ed_len.pop_front(); ef = ed_flags.pop_front();
          chk(int'(desc_len) == el, "R7", "packet length", desc_len, el);
          chk(desc_flags == ef, "R8", "descriptor flags", desc_flags, ef);
        end
      end
    end
  end

  task automatic push_word(input byte unsigned b[$], input string tg[$],
                           input int first, input int n, input bit s, input bit e);
    logic [31:0] d = '0;
    for (int i = 0; i < n; i++) d[8*i +: 8] = b[first + i];
    ew_data.push_back(d);
    ew_be.push_back(4'((1 << n) - 1));
    ew_sop.push_back(s);
    ew_eop.push_back(e);
    ew_tag.push_back(tg[first + n - 1]);
  endtask

  int pid = 0;

  // one packet: nw payload words, k valid bytes in the last one
  task automatic send_pkt(input int nw, input int k, input bit ev, input bit et,
                          input bit ec, input bit scramble);
    byte unsigned bq[$];
    string        tq[$];
    logic [31:0]  vw, cw, wd;
    logic [63:0]  tv;
    int           tot;
    pid++;
    vw = 32'hA500_0000 ^ (pid * 32'h0001_0203);
    tv = {32'h7100_0000 + pid, 32'h1200_0000 ^ (pid * 32'h0101_0101)};
    cw = 32'hC0DE_0000 + pid * 32'h0000_1357;
    if (ev) for (int i = 0; i < 4; i++) begin bq.push_back(vw[8*i +: 8]); tq.push_back("R2"); end
    if (et) for (int i = 0; i < 8; i++) begin bq.push_back(tv[8*i +: 8]); tq.push_back("R3"); end
    for (int w = 0; w < nw; w++) begin
      wd = {8'(pid), 8'(w), 8'h3C ^ 8'(w), 8'hC3};
      for (int i = 0; i < ((w == nw - 1) ? k : 4); i++) begin
        bq.push_back(wd[8*i +: 8]); tq.push_back("R4");
      end
    end
    if (ec) for (int i = 0; i < 4; i++) begin
      bq.push_back(cw[8*i +: 8]); tq.push_back((k == 4) ? "R5" : "R6");
    end
    tot = bq.size();
    for (int p = 0; p < tot; p += 4)
      push_word(bq, tq, p, (tot - p >= 4) ? 4 : tot - p, p == 0, p + 4 >= tot);
    ed_len.push_back(tot % (1 << LEN_W));
    ed_flags.push_back((32'(ev) << 19) | (32'(et) << 15) | (32'(ec) << 12));

    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {8'(pid), 8'(w), 8'h3C ^ 8'(w), 8'hC3};
      in_sop   = (w == 0);
      in_eop   = (w == nw - 1);
      in_be    = (w == nw - 1) ? 4'((1 << k) - 1) : 4'b1111;
      if (w == 0) begin
        en_vlan = ev; en_ts = et; en_csum = ec;
        vlan_word = vw; ts_value = tv; csum_word = cw;
      end else if (scramble) begin
        en_vlan = lfsr[0]; en_ts = lfsr[1]; en_csum = lfsr[2];
        vlan_word = ~lfsr; ts_value = {lfsr, ~lfsr}; csum_word = lfsr ^ 32'h5555_AAAA;
      end
      #2;
      while (!in_ready) begin
        @(negedge clk);
        #2;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired pending=%0d", ew_data.size());
    done = 1'b1;
    report();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_be = 4'h0;
    in_data = '0; en_vlan = 1'b0; en_ts = 1'b0; en_csum = 1'b0;
    vlan_word = '0; ts_value = '0; csum_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!out_valid && !in_ready && !desc_valid, "R1", "reset state",
        {out_valid, in_ready, desc_valid}, 0);
    repeat (2) @(negedge clk);
    #2;
    chk(!out_valid && !desc_valid, "R1", "idle after reset", {out_valid, desc_valid}, 0);

    send_pkt(3, 4, 0, 0, 0, 0);   // plain pass-through, R4
    send_pkt(2, 2, 1, 0, 0, 0);   // classification only, R2
    send_pkt(1, 1, 0, 1, 0, 0);   // time only, R3
    send_pkt(4, 3, 1, 1, 0, 0);   // both prefixes in order, R2 R3
    send_pkt(2, 4, 0, 0, 1, 0);   // full last word, R5
    send_pkt(2, 1, 0, 0, 1, 0);   // R6 k=1
    send_pkt(3, 2, 0, 0, 1, 0);   // R6 k=2
    send_pkt(1, 3, 0, 0, 1, 0);   // R6 k=3, single word
    rdy_mode = 1;
    send_pkt(3, 3, 1, 1, 1, 0);   // all, alternating ready, R10
    rdy_mode = 2;
    send_pkt(4, 2, 1, 1, 1, 1);   // R9 inputs scrambled mid-packet
    send_pkt(70, 2, 1, 1, 1, 0);  // length wrap, R7
    for (int c = 0; c < 32; c++)
      send_pkt(1 + c % 5, 1 + c % 4, c[0], c[1], c[2], c[3]);
    rdy_mode = 0;
    send_pkt(2, 4, 1, 1, 1, 1);

    for (int i = 0; i < 200 && (ew_data.size() != 0 || ed_len.size() != 0); i++)
      @(negedge clk);
    repeat (3) @(negedge clk);
    #3;
    chk(ew_data.size() == 0 && ed_len.size() == 0, "R10", "words or descriptors missing",
        ew_data.size(), 0);
    done = 1'b1;
    report();
  end
endmodule